// File: doc/BRIEF.md
# Power-Up Fault Pin Supervisor

This host-side block watches the active-low error pin of a peripheral that it holds in reset. After the host lets the peripheral out of reset, that pin can drop low for several milliseconds. The drop comes from an undefined internal state that boot firmware clears later. A plain debounce cannot tell this pulse from a real fault. The supervisor therefore ignores the pin during a boot window. The window ends in one of two ways: the peripheral raises its ready interrupt, or a fixed post-reset timeout (nominally 25 ms) runs out, whichever comes first.

After the window closes, any low level on the pin counts as a genuine fault. If the pin is still low when the timeout ends, that also counts as a genuine fault. The fault is latched until the host resets the peripheral again. A separate flag records that boot ended by timeout rather than by the ready interrupt. Both the error pin and the ready interrupt are asynchronous to the host clock, so each passes through a two-flop synchronizer. The timeout is a parameter given as a number of clock cycles.

Top module: `pwrup_fault_supervisor`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next cycle shows `state_o` = 0 (in reset), `fault_o` = 0 and `boot_timeout_o` = 0. The state codes are 0 in reset, 1 boot wait, 2 monitoring, 3 fault.
- R2: If `periph_rst_n` is low at a rising edge, the next cycle shows `state_o` = 0 with both flags cleared, whatever the state was before.
- R3: If the supervisor is in state 0 and `periph_rst_n` is high at an edge, it enters state 1. With no ready interrupt, it stays in state 1 for exactly `TIMEOUT_CYC` cycles. While in state 1 the error pin has no effect, and `fault_o` stays 0 until the timeout ends.
- R4: When the synchronized ready interrupt is high at an edge in state 1, the supervisor moves to state 2 without waiting for the timer, and `boot_timeout_o` stays 0.
- R5: When the timer ends in state 1 with no synchronized ready, `boot_timeout_o` is set. If the synchronized error pin is low at that edge, the supervisor goes to state 3 and sets `fault_o`. Otherwise it goes to state 2.
- R6: In state 2, a low synchronized error pin at an edge moves the supervisor to state 3 and sets `fault_o`.
- R7: State 3, `fault_o` and `boot_timeout_o` hold whatever the error pin and ready interrupt do. Only R1 or R2 clears them.
- R8: The error pin and the ready interrupt each pass through two flops. A level that is stable before rising edge n acts on the state first at edge n+2.
- R9: When the synchronized ready and the timer end fall on the same edge, ready wins. The supervisor enters state 2 with `boot_timeout_o` = 0 and `fault_o` = 0, even if the error pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host system clock |
| rst_n | input | 1 | Synchronous active-low reset of the supervisor |
| periph_rst_n | input | 1 | Host-driven peripheral reset line, high means released (clock-domain synchronous) |
| err_pin_n | input | 1 | Peripheral error pin, active low, asynchronous |
| rdy_irq | input | 1 | Peripheral ready interrupt, active high, asynchronous |
| fault_o | output | 1 | Sticky genuine-fault flag |
| boot_timeout_o | output | 1 | Boot window closed by timeout instead of by ready |
| state_o | output | 2 | Supervisor state code (0..3) |

## Verification
Two events can fall on the same edge: the ready interrupt arriving and the boot timer running out. They ask for different outcomes, so R9 sets the order between them. The bench provokes the tie on purpose. It raises the interrupt exactly two edges before the timer's final edge, which covers the synchronizer delay, and holds the error pin low at the same time. It then expects monitoring state with both flags clear. Random runs add further near-ties, and a reference model in the bench judges every cycle.

// File: rtl/sup_pkg.sv
// Package: shared state encoding for the power-up fault supervisor.
// Assumes: the state codes are visible on a port, so the values are fixed.
package sup_pkg;

    typedef enum logic [1:0] {
        ST_IN_RESET  = 2'd0,
        ST_BOOT_WAIT = 2'd1,
        ST_MONITOR   = 2'd2,
        ST_FAULT     = 2'd3
    } sup_state_e;

endpackage

// File: rtl/sup_sync.sv
// Module: multi-bit, multi-stage level synchronizer. Each bit is independent.
// Assumes: inputs are slow levels, so bits need no mutual coherence.
// The synchronous reset loads RST_VAL into every stage.
module sup_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage captures the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= d_async;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // Each later stage re-registers its predecessor.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[gi] <= RST_VAL;
                else        stage_q[gi] <= stage_q[gi-1];
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/sup_boot_timer.sv
// Module: boot-window timer. It counts cycles while enabled and stops at its final count.
// Assumes: TIMEOUT_CYC >= 2. The clear input holds the count at zero outside the window.
module sup_boot_timer #(
    parameter int TIMEOUT_CYC = 2_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);

    localparam int               CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count up inside the window and hold once the final count is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)  cnt_q <= '0;
        else if (!expired)    cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == LAST);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R3

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/sup_fsm.sv
// Module: supervisor state machine. It decides when the error pin counts and latches faults.
// Assumes: err_ok_n and rdy come from synchronizers, and periph_rst_n is in the clk domain.
// When the ready interrupt and the timer's end fall on the same edge, ready takes priority.
module sup_fsm
    import sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       periph_rst_n,
    input  logic       err_ok_n,
    input  logic       rdy,
    input  logic       tmr_expired,
    output logic       tmr_clear,
    output logic [1:0] state_o,
    output logic       fault_o,
    output logic       boot_timeout_o
);

    sup_state_e state_q, state_d;
    logic       fault_q, fault_d;
    logic       tout_q, tout_d;

    // Next-state and flag logic. Peripheral reset overrides every state.
    always_comb begin
        state_d = state_q;
        fault_d = fault_q;
        tout_d  = tout_q;
        if (!periph_rst_n) begin
            state_d = ST_IN_RESET;
            fault_d = 1'b0;
            tout_d  = 1'b0;
        end else begin
            unique case (state_q)
                ST_IN_RESET:  state_d = ST_BOOT_WAIT;
                ST_BOOT_WAIT: begin
                    if (rdy) begin
                        state_d = ST_MONITOR;
                    end else if (tmr_expired) begin
                        tout_d = 1'b1;
                        if (!err_ok_n) begin
                            state_d = ST_FAULT;
                            fault_d = 1'b1;
                        end else begin
                            state_d = ST_MONITOR;
                        end
                    end
                end
                ST_MONITOR: begin
                    if (!err_ok_n) begin
                        state_d = ST_FAULT;
                        fault_d = 1'b1;
                    end
                end
                ST_FAULT:     state_d = ST_FAULT;
                default:      state_d = ST_IN_RESET;
            endcase
        end
    end

    // State and flag registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IN_RESET;
            fault_q <= 1'b0;
            tout_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            fault_q <= fault_d;
            tout_q  <= tout_d;
        end
    end

    assign tmr_clear      = (state_q != ST_BOOT_WAIT);
    assign state_o        = state_q;
    assign fault_o        = fault_q;
    assign boot_timeout_o = tout_q;

    AST_PERIPH_RST_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_rst_n |=> (state_q == ST_IN_RESET && !fault_q && !tout_q)); // R2

    AST_NO_EARLY_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT_WAIT && !tmr_expired) |=> !fault_q); // R3

    AST_RDY_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT_WAIT && rdy && periph_rst_n) |=> (state_q == ST_MONITOR && !tout_q)); // R4

    AST_TIMEOUT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT_WAIT && tmr_expired && !rdy && periph_rst_n) |=> tout_q); // R5

    AST_MON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MONITOR && !err_ok_n && periph_rst_n) |=> (state_q == ST_FAULT && fault_q)); // R6

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT && periph_rst_n) |=> (state_q == ST_FAULT && fault_q && $stable(tout_q))); // R7

    AST_TIE_READY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT_WAIT && rdy && tmr_expired && periph_rst_n) |=> (!tout_q && !fault_q)); // R9

endmodule

// File: rtl/pwrup_fault_supervisor.sv
// Module: top of the power-up fault pin supervisor. It joins the synchronizers, the boot timer and the FSM.
// Assumes: clk is the host clock and TIMEOUT_CYC is the boot window in clk cycles.
// The default is 25 ms at 100 MHz.
module pwrup_fault_supervisor #(
    parameter int TIMEOUT_CYC = 2_500_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       periph_rst_n,
    input  logic       err_pin_n,
    input  logic       rdy_irq,
    output logic       fault_o,
    output logic       boot_timeout_o,
    output logic [1:0] state_o
);

    localparam int ERR_BIT = 1;
    localparam int RDY_BIT = 0;

    logic [1:0] sync_q;
    logic       tmr_clear;
    logic       tmr_expired;

    // Error pin resets high (idle) and the interrupt resets low.
    sup_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b10)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({err_pin_n, rdy_irq}),
        .q_sync  (sync_q)
    );

    sup_boot_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .expired (tmr_expired)
    );

    sup_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .periph_rst_n   (periph_rst_n),
        .err_ok_n       (sync_q[ERR_BIT]),
        .rdy            (sync_q[RDY_BIT]),
        .tmr_expired    (tmr_expired),
        .tmr_clear      (tmr_clear),
        .state_o        (state_o),
        .fault_o        (fault_o),
        .boot_timeout_o (boot_timeout_o)
    );

endmodule

// File: tb/sim_pwrup_fault_supervisor.sv
// Bench: drives inputs at falling edges and steps a reference model at each rising edge.
// It compares the outputs at the next falling edge.
module sim_pwrup_fault_supervisor;

    localparam int CLK_PERIOD = 10;
    localparam int T_CYC      = 20;
    localparam int WDOG_CYC   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       periph_rst_n = 1'b0;
    logic       err_pin_n = 1'b1;
    logic       rdy_irq = 1'b0;
    logic       fault_o, boot_timeout_o;
    logic [1:0] state_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model state
    int m_state = 0;
    int m_cnt   = 0;
    bit m_fault = 0, m_tout = 0;
    bit m_e1 = 1, m_e2 = 1, m_r1 = 0, m_r2 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrup_fault_supervisor #(.TIMEOUT_CYC(T_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .periph_rst_n(periph_rst_n),
        .err_pin_n(err_pin_n), .rdy_irq(rdy_irq),
        .fault_o(fault_o), .boot_timeout_o(boot_timeout_o), .state_o(state_o)
    );

    // Next state from R2..R6 and R9, using the pre-edge synchronized values
    function automatic int f_next_state(int st, bit p, bit e2, bit r2, int cnt);
        if (!p) return 0;
        case (st)
            0: return 1;
            1: if (r2) return 2; else if (cnt == T_CYC-1) return (e2 ? 2 : 3); else return 1;
            2: return (e2 ? 2 : 3);
            default: return 3;
        endcase
    endfunction

    // One rising edge of the reference model
    task automatic model_edge(bit p, bit e, bit r);
        int nst;
        nst = f_next_state(m_state, p, m_e2, m_r2, m_cnt);
        if (!p) begin
            m_fault = 0; m_tout = 0;
        end else begin
            if (m_state == 1 && !m_r2 && m_cnt == T_CYC-1) m_tout = 1;
            if (nst == 3 && m_state != 3) m_fault = 1;
        end
        if (nst == 1 && m_state == 1) m_cnt = m_cnt + 1; else m_cnt = 0;
        m_state = nst;
        m_e2 = m_e1; m_e1 = e; m_r2 = m_r1; m_r1 = r;
    endtask

    task automatic check(string tag, int exp_st, bit exp_f, bit exp_t);
        checks++;
        if (int'(state_o) != exp_st || fault_o !== exp_f || boot_timeout_o !== exp_t) begin
            errors++;
            $display("FAIL %s: state/fault/timeout actual %0d/%0b/%0b expected %0d/%0b/%0b",
                     tag, state_o, fault_o, boot_timeout_o, exp_st, exp_f, exp_t);
        end
    endtask

    // Drive at the current falling edge, step the model at the rising edge, compare at the next falling edge
    task automatic step(string tag, bit p, bit e, bit r);
        periph_rst_n = p; err_pin_n = e; rdy_irq = r;
        @(posedge clk);
        model_edge(p, e, r);
        @(negedge clk);
        check(tag, m_state, m_fault, m_tout);
    endtask

    initial begin : wdog
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd4711));
        @(negedge clk);
        repeat (3) @(negedge clk);
        check("R1 reset", 0, 0, 0);
        rst_n = 1'b1;

        // R2: peripheral held in reset
        for (int i = 0; i < 3; i++) step("R2 held", 0, 1, 0);

        // R3/R5: spurious low during boot, clears before the timeout, no ready
        step("R3 release", 1, 0, 0);
        for (int i = 1; i < T_CYC; i++) begin
            step("R3 boot ignore", 1, (i < T_CYC-5) ? 1'b0 : 1'b1, 0);
            if (i == T_CYC-1) check("R3 still boot wait", 1, 0, 0);
        end
        step("R5 expiry pin high", 1, 1, 0);
        check("R5 timeout to monitor", 2, 0, 1);

        // R8: latency of the error pin in monitoring
        step("R8 drop", 1, 0, 0);
        check("R8 no effect edge1", 2, 0, 1);
        step("R8 hold", 1, 0, 0);
        check("R8 no effect edge2", 2, 0, 1);
        step("R6 fault", 1, 0, 0);
        check("R6 fault", 3, 1, 1);

        // R7: sticky under input activity
        for (int i = 0; i < 6; i++) step("R7 sticky", 1, i[0], ~i[0]);
        check("R7 sticky end", 3, 1, 1);

        // R2: peripheral reset clears the fault
        step("R2 clear", 0, 1, 0);
        check("R2 clear", 0, 0, 0);

        // R4: early ready
        step("R4 release", 1, 0, 0);
        for (int i = 0; i < 4; i++) step("R4 wait", 1, 0, (i >= 1));
        check("R4 early monitor", 2, 0, 0);
        step("R2 again", 0, 1, 0);

        // R5: pin still low at expiry
        step("R5 release", 1, 0, 0);
        for (int i = 1; i <= T_CYC; i++) step("R5 boot", 1, 0, 0);
        check("R5 expiry fault", 3, 1, 1);
        step("R2 again", 0, 1, 0);

        // R9: ready and expiry on the same edge, pin low
        step("R9 release", 1, 0, 0);
        for (int i = 1; i <= T_CYC; i++) step("R9 boot", 1, 0, (i >= T_CYC-2));
        check("R9 ready wins", 2, 0, 0);
        step("R2 again", 0, 1, 0);

        // Random phase: a mix of boot windows and near-ties, judged by the model
        for (int i = 0; i < 4000; i++) begin
            bit p, e, r;
            p = ($urandom_range(0, 59) != 0);
            e = ($urandom_range(0, 9) > 1);
            r = ($urandom_range(0, 29) == 0) || (m_state == 2 && $urandom_range(0, 1) == 1);
            step("R3/R4/R5/R6/R7/R9 random", p, e, r);
        end

        // R1: mid-run system reset
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid reset", 0, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule